// File: doc/BRIEF.md
# Dual-Channel Sample Capture Buffer

This block records one fixed-length burst of samples from two converter channels that sample in step, and then lets a slower host read the stored record back at random. Both channels share one sample clock and one capture address counter. Each channel writes into its own memory at the shared address. A start pulse begins a record at address 0. When the last location has been written, the block stops, raises done and keeps the record until the next start.

The sample clock is derived inside the block from the system clock, with a period of `DIV` system cycles. The capture address changes only in the cycle in which the sample clock rises. The write strobe covers one system cycle in the high half of the sample clock, one cycle after the address has moved. No write can therefore reach a location while the address is changing. The read port is registered and has one cycle of latency. While a capture runs, it returns zeros, so a host never sees a record that is only partly written.

Top module: `capbuf_top`

## Requirements
- R1: After reset, busy_o, done_o, wr_o and sclk_o are 0, cap_addr_o is 0 and rd_data_o is 0.
- R2: A start_i pulse sampled while not busy starts a capture. In the next cycle busy_o=1, done_o=0 and cap_addr_o=0, and that cycle is phase 0 of the first sample period. This holds whether the block was idle or done.
- R3: While busy, sclk_o is 1 in phases 0 to DIV/2-1 of every DIV-cycle sample period and 0 in the remaining phases, so it rises only at phase 0.
- R4: cap_addr_o changes only on entry to phase 0, and then by +1 (or to 0 on a start). It holds k throughout the k-th sample period.
- R5: wr_o is 1 in exactly one cycle of each sample period, phase 1. In that cycle sclk_o is high and cap_addr_o has held its value for at least one cycle.
- R6: In a wr_o cycle, each channel c stores smp_i[c*DW +: DW] at cap_addr_o. Channel 0 occupies the low DW bits.
- R7: After phase DIV-1 of the sample period at address 2**AW-1, busy_o falls and done_o rises together. wr_o stays 0 until the next start, so a record holds exactly 2**AW writes and never wraps.
- R8: A start_i pulse while busy_o=1 is ignored. The phase, the address and the record end are unchanged.
- R9: When not busy, rd_data_o shows, one cycle after rd_addr_i is presented, the bytes of both channels stored at that address. Channel c occupies [c*DW +: DW].
- R10: In every cycle that follows a cycle with busy_o=1, rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture start pulse |
| smp_i | input | NCH*DW | Converter samples, channel c at [c*DW +: DW] |
| rd_addr_i | input | AW | Read address |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | Complete record held |
| sclk_o | output | 1 | Derived sample clock to the converters |
| wr_o | output | 1 | Gated memory write strobe |
| cap_addr_o | output | AW | Shared capture address |
| rd_data_o | output | NCH*DW | Read data, channel c at [c*DW +: DW] |

## Verification
The bench builds the block with DIV=4, AW=5, NCH=2 and DW=8. A record is then 32 samples of 4 cycles each, so several complete captures fit into a short run. Those captures include restarts from done, starts issued during every phase of a running capture, and the final sample period at the top address. The short period puts the strobe phase right next to both the address change and the falling sample clock. A wrong phase decode therefore shows up at once.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RUN  = 2'd1,
        CS_DONE = 2'd2
    } cap_state_e;

endpackage

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
    import capbuf_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DIV = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          sclk_o,
    output logic          wr_o,
    output logic [AW-1:0] addr_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 2;
    localparam int HALF = DIV / 2;
    localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] PH_WR   = PW'(1);
    localparam logic [PW-1:0] PH_HALF = PW'(HALF);
    localparam logic [AW-1:0] A_LAST  = {AW{1'b1}};

    typedef struct packed {
        cap_state_e    st;
        logic [PW-1:0] ph;
        logic [AW-1:0] addr;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  run;

    assign run = (s_q.st == CS_RUN);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            if (start_i) begin
                s_d.st   = CS_RUN;
                s_d.ph   = '0;
                s_d.addr = '0;
            end
        end else if (s_q.ph == PH_LAST) begin
            s_d.ph = '0;
            if (s_q.addr == A_LAST) begin
                s_d.st = CS_DONE;
            end else begin
                s_d.addr = s_q.addr + AW'(1);
            end
        end else begin
            s_d.ph = s_q.ph + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: CS_IDLE, ph: '0, addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = run;
    assign done_o = (s_q.st == CS_DONE);
    assign sclk_o = run && (s_q.ph < PH_HALF);
    assign wr_o   = run && (s_q.ph == PH_WR);
    assign addr_o = s_q.addr;

    p_sclk_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (s_q.ph == '0));

    p_addr_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_o) |-> (s_q.ph == '0));

    p_wr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (sclk_o && $stable(addr_o)));

    p_end_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_no_wr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_o);

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && s_q.ph != PH_LAST) |=>
            (busy_o && s_q.ph == $past(s_q.ph) + PW'(1)));

endmodule

// File: rtl/capbuf_store.sv
module capbuf_store #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          blank_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = blank_i ? '0 : mem_q[raddr_i];
    end

    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q;

    p_blank_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> (rdata_o == '0));

endmodule

// File: rtl/capbuf_top.sv
module capbuf_top #(
    parameter int DW  = 8,
    parameter int AW  = 8,
    parameter int NCH = 2,
    parameter int DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NCH*DW-1:0] smp_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              wr_o,
    output logic [AW-1:0]     cap_addr_o,
    output logic [NCH*DW-1:0] rd_data_o
);
    logic          busy, wr;
    logic [AW-1:0] addr;

    capbuf_ctrl #(.AW(AW), .DIV(DIV)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .busy_o  (busy),
        .done_o  (done_o),
        .sclk_o  (sclk_o),
        .wr_o    (wr),
        .addr_o  (addr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        capbuf_store #(.DW(DW), .AW(AW)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr),
            .waddr_i (addr),
            .wdata_i (smp_i[c*DW +: DW]),
            .blank_i (busy),
            .raddr_i (rd_addr_i),
            .rdata_o (rd_data_o[c*DW +: DW])
        );
    end

    assign busy_o     = busy;
    assign wr_o       = wr;
    assign cap_addr_o = addr;

    p_start_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o && cap_addr_o == '0));

endmodule

// File: tb/capbuf_top_bench.sv
module capbuf_top_bench;
    localparam int DW = 8;
    localparam int AW = 5;
    localparam int NCH = 2;
    localparam int DIV = 4;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [NCH*DW-1:0] smp_i = '0;
    logic [AW-1:0]     rd_addr_i = '0;
    logic              busy_o, done_o, sclk_o, wr_o;
    logic [AW-1:0]     cap_addr_o;
    logic [NCH*DW-1:0] rd_data_o;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] model [NCH][DEPTH];

    always #4 clk = ~clk;

    capbuf_top #(.DW(DW), .AW(AW), .NCH(NCH), .DIV(DIV)) u_capbuf_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_i(smp_i),
        .rd_addr_i(rd_addr_i), .busy_o(busy_o), .done_o(done_o),
        .sclk_o(sclk_o), .wr_o(wr_o), .cap_addr_o(cap_addr_o),
        .rd_data_o(rd_data_o)
    );

    function automatic logic exp_sclk(int p);
        return p < DIV / 2;
    endfunction

    function automatic logic exp_wr(int p);
        return p == 1;
    endfunction

    function automatic logic [NCH*DW-1:0] exp_rd(int a);
        logic [NCH*DW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*DW +: DW] = model[c][a];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic capture(bit stress);
        @(negedge clk);
        start_i = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            for (int p = 0; p < DIV; p++) begin
                @(negedge clk);
                start_i = 1'b0;
                if (k == 0 && p == 0) begin
                    chk("R2 busy", busy_o, 1);
                    chk("R2 done", done_o, 0);
                end
                chk("R3 sclk", sclk_o, exp_sclk(p));
                chk("R4 addr", cap_addr_o, k);
                chk("R5 wr", wr_o, exp_wr(p));
                if (k > 0 || p > 0) chk("R10 blank", rd_data_o, 0);
                rd_addr_i = AW'($urandom);
                smp_i = (NCH*DW)'($urandom);
                if (exp_wr(p)) begin
                    for (int c = 0; c < NCH; c++) model[c][k] = smp_i[c*DW +: DW];
                end
                if (stress && ($urandom % 5 == 0)) start_i = 1'b1; // R8 ignored start
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 busy end", busy_o, 0);
        chk("R7 done", done_o, 1);
        chk("R7 wr", wr_o, 0);
        chk("R7 addr held", cap_addr_o, DEPTH - 1);
        repeat (3) begin
            @(negedge clk);
            chk("R7 no wrap wr", wr_o, 0);
        end
    endtask

    task automatic read_back(int n_rand);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            rd_addr_i = AW'(a);
            @(negedge clk);
            chk("R9 read", rd_data_o, exp_rd(a));
            chk("R6 ch0", rd_data_o[DW-1:0], model[0][a]);
        end
        for (int i = 0; i < n_rand; i++) begin
            @(negedge clk);
            rd_addr_i = AW'($urandom);
            @(negedge clk);
            chk("R9 random read", rd_data_o, exp_rd(int'(rd_addr_i)));
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 wr", wr_o, 0);
        chk("R1 sclk", sclk_o, 0);
        chk("R1 addr", cap_addr_o, 0);
        chk("R1 rd", rd_data_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", busy_o, 0);
        capture(1'b0);
        read_back(10);
        for (int r = 0; r < 5; r++) begin
            capture(1'b1);   // R2 restart from done, R8 stray starts
            read_back(20);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule